// File: doc/BRIEF.md
# Microprogrammed Control Sequencer

This block steps through a small control memory and turns each stored microword into a set of control strobes for a processor datapath. A shared fetch microroutine sits at the start of the control memory. Its last word tells the sequencer to jump to the execution microroutine for the opcode currently on the `opcode` input. The jump target comes from a start-address table with one entry per opcode. The last word of every execution microroutine sends the micro program counter back to zero, so the next fetch begins on the following clock.

Two microword encodings are available, chosen by a parameter. In the default combined format, the strobes fall into three groups that never need two members active at once. These are bus drivers, bus loaders and operations. Each group holds a 3-bit binary field that is decoded to one-hot, and code 0 leaves the whole group idle. In the horizontal format, every microword bit drives one strobe directly. For the same microprogram, both formats produce the same strobes on the same cycles.

The microword is registered before decoding. The strobes for control-memory address N therefore appear one clock after the micro program counter reaches N.

Top module: `useq_ctrl`

## Requirements
- R1: `rst` is synchronous and active high. While it is held, `ctrl` is all zero and the micro program counter is zero. On the first clock after release, the strobes of fetch step 0 appear.
- R2: Without a sequencing bit, the micro program counter advances by one per clock. The fetch routine runs in this order, as (driver, loader, operation): (PC, MAR, none), (MAR, MBR, read), (MBR, IR, none), (none, none, PC increment). The last of these steps ends the fetch.
- R3: At the end of a fetch, the next microword comes from the start address of the opcode present in that cycle. The opcode value at any other time has no effect on the running routine.
- R4: The end-of-execution bit in a microword makes the fetch routine start on the next cycle.
- R5: Code k (1 to 7) of group g drives `ctrl[g*7 + k - 1]`. Group 0 holds the bus drivers, coded 1 PC, 2 IR, 3 ACC, 4 MBR, 5 MAR. Group 1 holds the bus loaders, coded 1 MAR, 2 MBR, 3 IR, 4 ACC, 5 PC. Group 2 holds the operations, coded 1 read, 2 write, 3 PC increment, 4 add, 5 subtract.
- R6: Code 0 in a group field turns off every strobe of that group. At most one strobe per group is ever active.
- R7: The four defined opcodes run these execution routines. LOAD (0x40): (IR, MAR, none), (MAR, MBR, read), (MBR, ACC, none). ADD (0x41): (IR, MAR, none), (MAR, MBR, read), (MBR, ACC, add). STORE (0x42): (IR, MAR, none), (ACC, MBR, none), (MAR, none, write). JUMP (0x43): (IR, PC, none).
- R8: Every other opcode runs a single all-off step that ends execution.
- R9: With the horizontal format selected, `ctrl` matches the combined format cycle for cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 8 | Opcode from the instruction register |
| ctrl | output | 21 | Control strobes, grouped as in R5 |

## Verification
The bench targets the points where the micro program counter changes course. These are the end-of-fetch jump, the return to zero at the end of execution, the one-step routine for undefined opcodes at both ends of the opcode range, and a reset in the middle of a routine. A sequencer that sampled the opcode outside the end-of-fetch cycle would switch routines partway through when the opcode changes. One that took its branch decision from the registered microword would insert an extra step or drop one at each boundary. A wrong field decode would light the wrong strobe or two strobes in one group. Running a horizontal-format copy alongside shows up any word that the format conversion got wrong.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int OPW = 8,
  parameter int UAW = 4,
  parameter int FW = 3,
  parameter int NG = 3,
  parameter bit HORIZ = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [OPW-1:0]              opcode,
  output logic [NG*(2**FW-1)-1:0]     ctrl
);
  localparam int CPG = 2**FW - 1;
  localparam int NCTRL = NG * CPG;
  localparam int CW = NG * FW;
  localparam int BW = HORIZ ? NCTRL : CW;
  localparam int UW = BW + 2;
  localparam int UDEPTH = 2**UAW;
  localparam int NOP = 2**OPW;

  function automatic logic [CW+1:0] enc(input int d, input int l, input int o,
                                        input logic ef, input logic ee);
    logic [CW+1:0] w;
    w = '0;
    w[0] = ef;
    w[1] = ee;
    w[2 +: FW] = FW'(d);
    w[2+FW +: FW] = FW'(l);
    w[2+2*FW +: FW] = FW'(o);
    return w;
  endfunction

  function automatic logic [CW+1:0] prog(input int a);
    case (a)
      0:  return enc(1, 1, 0, 1'b0, 1'b0);
      1:  return enc(5, 2, 1, 1'b0, 1'b0);
      2:  return enc(4, 3, 0, 1'b0, 1'b0);
      3:  return enc(0, 0, 3, 1'b1, 1'b0);
      4:  return enc(2, 1, 0, 1'b0, 1'b0);
      5:  return enc(5, 2, 1, 1'b0, 1'b0);
      6:  return enc(4, 4, 0, 1'b0, 1'b1);
      7:  return enc(2, 1, 0, 1'b0, 1'b0);
      8:  return enc(5, 2, 1, 1'b0, 1'b0);
      9:  return enc(4, 4, 4, 1'b0, 1'b1);
      10: return enc(2, 1, 0, 1'b0, 1'b0);
      11: return enc(3, 2, 0, 1'b0, 1'b0);
      12: return enc(5, 0, 2, 1'b0, 1'b1);
      13: return enc(2, 5, 0, 1'b0, 1'b1);
      14: return enc(0, 0, 0, 1'b0, 1'b1);
      default: return '0;
    endcase
  endfunction

  function automatic logic [UW-1:0] to_word(input logic [CW+1:0] c);
    logic [UW-1:0] w;
    w = '0;
    w[1:0] = c[1:0];
    if (HORIZ) begin
      for (int g = 0; g < NG; g++)
        for (int k = 1; k <= CPG; k++)
          w[2 + g*CPG + k - 1] = (c[2 + g*FW +: FW] == FW'(k));
    end else begin
      w[CW+1:0] = c;
    end
    return w;
  endfunction

  function automatic int start_of(input int op);
    case (op)
      8'h40:   return 4;
      8'h41:   return 7;
      8'h42:   return 10;
      8'h43:   return 13;
      default: return 14;
    endcase
  endfunction

  logic [UW-1:0]  cmem [UDEPTH];
  logic [UAW-1:0] stab [NOP];

  initial begin
    for (int i = 0; i < UDEPTH; i++) cmem[i] = to_word(prog(i));
    for (int i = 0; i < NOP; i++) stab[i] = UAW'(start_of(i));
  end

  logic [UAW-1:0] upc;
  logic [UW-1:0]  uir;
  logic [UW-1:0]  cur;

  assign cur = cmem[upc];

  always_ff @(posedge clk) begin
    if (rst) begin
      upc <= '0;
      uir <= '0;
    end else begin
      uir <= cur;
      if (cur[1])      upc <= '0;
      else if (cur[0]) upc <= stab[opcode];
      else             upc <= upc + 1'b1;
    end
  end

  generate
    if (HORIZ) begin : g_horiz
      assign ctrl = uir[UW-1:2];
    end else begin : g_comb
      for (genvar g = 0; g < NG; g++) begin : g_grp
        for (genvar k = 1; k <= CPG; k++) begin : g_code
          assign ctrl[g*CPG + k - 1] = (uir[2 + g*FW +: FW] == FW'(k));
        end
      end
    end
  endgenerate
endmodule

// File: rtl/useq_ctrl_chk.sv
module useq_ctrl_chk #(
  parameter int UAW = 4,
  parameter int FW = 3,
  parameter int NG = 3,
  parameter int UW = 11
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NG*(2**FW-1)-1:0] ctrl,
  input logic [UAW-1:0]          upc,
  input logic [UW-1:0]           uir
);
  localparam int CPG = 2**FW - 1;

  a_r1_reset_quiet: assert property (@(posedge clk) rst |=> ctrl == '0);

  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && uir[1:0] == 2'b00) |-> upc == $past(upc) + 1'b1);

  a_r3_fetch_jump: assert property (@(posedge clk) disable iff (rst)
    (uir[0] && !uir[1]) |-> upc != '0);

  a_r4_exec_return: assert property (@(posedge clk) disable iff (rst)
    uir[1] |-> upc == '0);

  generate
    for (genvar g = 0; g < NG; g++) begin : g_oh
      a_r6_group_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ctrl[g*CPG +: CPG]));
    end
  endgenerate
endmodule

bind useq_ctrl useq_ctrl_chk #(.UAW(UAW), .FW(FW), .NG(NG), .UW(UW)) u_chk (
  .clk(clk), .rst(rst), .ctrl(ctrl), .upc(upc), .uir(uir));

// File: tb/sim_useq_ctrl.sv
module sim_useq_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] opcode = 8'h00;
  logic [20:0] ctrl0, ctrl1;
  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  useq_ctrl u0 (.clk(clk), .rst(rst), .opcode(opcode), .ctrl(ctrl0));
  useq_ctrl #(.HORIZ(1'b1)) u1 (.clk(clk), .rst(rst), .opcode(opcode), .ctrl(ctrl1));

  function automatic logic [20:0] ex(input int d, input int l, input int o);
    logic [20:0] v;
    v = '0;
    if (d != 0) v[0*7 + d - 1] = 1'b1;
    if (l != 0) v[1*7 + l - 1] = 1'b1;
    if (o != 0) v[2*7 + o - 1] = 1'b1;
    return v;
  endfunction

  task automatic check(input logic ok, input string tag, input logic [20:0] got, input logic [20:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(input logic [20:0] exp, input string tag);
    @(negedge clk);
    check(ctrl0 === exp, tag, ctrl0, exp);
    check(ctrl1 === ctrl0, "R9 horizontal matches combined", ctrl1, ctrl0);
    for (int g = 0; g < 3; g++)
      check($countones(ctrl0[g*7 +: 7]) <= 1, "R6 one per group", ctrl0, exp);
  endtask

  task automatic fetch();
    step(ex(1, 1, 0), "R1 R2 fetch step 0");
    step(ex(5, 2, 1), "R2 fetch step 1");
    step(ex(4, 3, 0), "R2 fetch step 2");
    step(ex(0, 0, 3), "R2 R3 fetch end");
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(ctrl0 === '0, "R1 reset state", ctrl0, '0);
    check(ctrl1 === '0, "R1 reset state horizontal", ctrl1, '0);
    rst = 1'b0;
  endtask

  task automatic t_load();
    opcode = 8'h40;
    fetch();
    step(ex(2, 1, 0), "R7 load 0");
    step(ex(5, 2, 1), "R7 R5 load 1");
    step(ex(4, 4, 0), "R7 R4 load end");
  endtask

  task automatic t_add();
    opcode = 8'h41;
    fetch();
    step(ex(2, 1, 0), "R7 add 0");
    step(ex(5, 2, 1), "R7 add 1");
    step(ex(4, 4, 4), "R7 R5 add end");
  endtask

  task automatic t_store();
    opcode = 8'h42;
    fetch();
    step(ex(2, 1, 0), "R7 store 0");
    step(ex(3, 2, 0), "R7 store 1");
    step(ex(5, 0, 2), "R7 R6 store end");
  endtask

  task automatic t_opcode_change();
    opcode = 8'h40;
    fetch();
    opcode = 8'h43;
    step(ex(2, 1, 0), "R3 opcode change ignored 0");
    step(ex(5, 2, 1), "R3 opcode change ignored 1");
    step(ex(4, 4, 0), "R3 opcode change ignored end");
    fetch();
    step(ex(2, 5, 0), "R7 R4 jump");
  endtask

  task automatic t_unknown();
    opcode = 8'h00;
    fetch();
    step(ex(0, 0, 0), "R8 R6 opcode 0x00");
    opcode = 8'hFF;
    fetch();
    step(ex(0, 0, 0), "R8 opcode 0xFF");
    opcode = 8'h44;
    fetch();
    step(ex(0, 0, 0), "R8 opcode 0x44");
  endtask

  task automatic t_reset_mid();
    opcode = 8'h41;
    fetch();
    step(ex(2, 1, 0), "R7 add before reset");
    rst = 1'b1;
    @(negedge clk);
    check(ctrl0 === '0, "R1 reset mid routine", ctrl0, '0);
    rst = 1'b0;
    opcode = 8'h42;
    fetch();
    step(ex(2, 1, 0), "R1 restart store 0");
    step(ex(3, 2, 0), "R1 restart store 1");
    step(ex(5, 0, 2), "R1 restart store end");
  endtask

  initial begin
    #100000;
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load();
    t_add();
    t_store();
    t_opcode_change();
    t_unknown();
    t_reset_mid();
    t_add();
    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule